// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an asynchronous 64K x 8 static RAM. The host offers one read or one write at a time on a valid/ready port. The sequencer latches the address and write byte, drives the memory's select, read-enable and write-strobe pins in the order the memory needs, and holds each phase for a whole number of clock cycles. For a read, it returns the byte on a one-cycle response pulse.

All phase lengths are worked out at elaboration time from picosecond minimums and the clock period. Each minimum is divided by the period, rounded up, and given a floor of one cycle. The controller never enables its own data driver while the memory may still be driving the shared bus. To ensure this, every write starts with a turnaround phase: the write strobe is low, the read enable is high and the driver is off. The driver switches on only after that phase.

Top module: `sram_ctrl`

## Requirements
- R1: During every cycle of an access, `mem_sel_n` is 0 and `mem_sel` is 1. In every other cycle, `mem_sel_n` is 1 and `mem_sel` is 0, and the two are never equal.
- R2: A read returns on `rsp_rdata` the byte last written to the same 16-bit address. All 16 address bits take part, including 0x0000 and 0xFFFF.
- R3: A read holds `mem_rd_n` low, with `mem_wr_n` high, for RD cycles. RD is the largest of the rounded-up access, enable-to-data and cycle minimums, which gives 3 cycles at the defaults (5000 ps period).
- R4: A write holds `mem_wr_n` low for a contiguous 4 cycles at the defaults, and `mem_rd_n` is high throughout every write.
- R5: The data driver `mem_dq_drive` turns on only after `mem_wr_n` has been low for the turnaround count (2 cycles at the defaults). It stays on for 3 cycles, and it turns off one cycle after `mem_wr_n` rises. The byte driven is then stored by the memory.
- R6: `req_ready` is 1 only when no access is in progress. It is 0 in the cycle after a request is accepted. `rsp_valid` is high for exactly one cycle: the cycle after the last read-wait cycle, which is also the first cycle in which `mem_rd_n` is high again.
- R7: While `rst` is high at a clock edge, the controller returns to idle, even in the middle of an access. After that edge, `mem_sel_n`, `mem_rd_n` and `mem_wr_n` are 1, `mem_sel` is 0, the driver is off, `rsp_valid` is 0 and `req_ready` is 1. An aborted write does not alter memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse, read byte on rsp_rdata |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 16 | Address pins to the memory |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_rd_n | output | 1 | Active-low output enable of the memory |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 8 | Byte the controller drives onto the data bus |
| mem_dq_in | input | 8 | Byte read from the data bus |
| mem_dq_drive | output | 1 | Controller drives the data bus when 1 |

## Verification
The hardest case to reach is a write accepted in the very first idle cycle after a read. In that case the memory may still be driving the bus, so the turnaround phase is the only thing that keeps the two drivers apart. The driver task polls `req_ready` on every falling edge and presents the next request at once, so a read followed by a write to the same address lands back to back. The monitor then measures how long the write strobe was low before the driver came on. A second hard case is a reset that arrives during a write's turnaround window. It is reached by issuing a write and asserting reset one cycle later, and a readback of that address then shows that the write did not land.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_WR_TURN,
    ST_WR_DRIVE,
    ST_WR_END
  } ctrl_state_e;

  // Minimum time in ps -> whole cycles, rounded up, never below one.
  function automatic int unsigned ps_to_cycles(int unsigned t_ps, int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles still needed after b cycles already spent toward a; at least one.
  function automatic int unsigned left_after(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : 1;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC   = 3,
  parameter int unsigned TURN_CYC = 2,
  parameter int unsigned DRV_CYC  = 2,
  parameter int unsigned CNT_W    = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  output ctrl_state_e state,
  output logic        accept,
  output logic        capture_now
);

  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_LAST  = CNT_W'(DRV_CYC - 1);

  ctrl_state_e      nxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phase_last;
  logic             last;

  always_comb begin
    case (state)
      ST_RD_WAIT:  phase_last = RD_LAST;
      ST_WR_TURN:  phase_last = TURN_LAST;
      ST_WR_DRIVE: phase_last = DRV_LAST;
      default:     phase_last = '0;
    endcase
  end

  assign last        = (cnt == phase_last);
  assign accept      = (state == ST_IDLE) && req_valid;
  assign capture_now = (state == ST_RD_WAIT) && last;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:     if (accept) nxt = req_write ? ST_WR_TURN : ST_RD_WAIT;
      ST_RD_WAIT:  if (last) nxt = ST_IDLE;
      ST_WR_TURN:  if (last) nxt = ST_WR_DRIVE;
      ST_WR_DRIVE: if (last) nxt = ST_WR_END;
      ST_WR_END:   nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state || state == ST_IDLE) cnt <= '0;
      else                                  cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture_now,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture_now) rdata_q <= mem_dq_in;
      rvalid_q <= capture_now;
    end
  end

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
(
  input  ctrl_state_e state,
  output logic        mem_sel_n,
  output logic        mem_sel,
  output logic        mem_rd_n,
  output logic        mem_wr_n,
  output logic        mem_dq_drive
);

  logic busy;

  assign busy         = (state != ST_IDLE);
  assign mem_sel_n    = ~busy;
  assign mem_sel      = busy;
  assign mem_rd_n     = ~(state == ST_RD_WAIT);
  assign mem_wr_n     = ~((state == ST_WR_TURN) || (state == ST_WR_DRIVE));
  assign mem_dq_drive = (state == ST_WR_DRIVE) || (state == ST_WR_END);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_PS       = 5000,
  parameter int unsigned T_ACC_PS     = 15000,
  parameter int unsigned T_RDEN_PS    = 7000,
  parameter int unsigned T_CYC_PS     = 15000,
  parameter int unsigned T_WRPULSE_PS = 10000,
  parameter int unsigned T_ADDRWR_PS  = 13000,
  parameter int unsigned T_SELWR_PS   = 13000,
  parameter int unsigned T_DSETUP_PS  = 9000,
  parameter int unsigned T_RELEASE_PS = 8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_drive
);

  // Read wait: address access, enable-to-data and cycle time all overlap.
  localparam int unsigned RD_CYC = max2(max2(ps_to_cycles(T_ACC_PS, CLK_PS),
                                             ps_to_cycles(T_RDEN_PS, CLK_PS)),
                                        ps_to_cycles(T_CYC_PS, CLK_PS));
  // Bus release window of the memory before the controller may drive.
  localparam int unsigned TURN_CYC = ps_to_cycles(T_RELEASE_PS, CLK_PS);
  // Drive phase: data setup, plus whatever strobe, address, select and cycle
  // minimums the turnaround phase has not already covered.
  localparam int unsigned DRV_CYC =
    max2(max2(ps_to_cycles(T_DSETUP_PS, CLK_PS),
              left_after(ps_to_cycles(T_WRPULSE_PS, CLK_PS), TURN_CYC)),
         max2(max2(left_after(ps_to_cycles(T_ADDRWR_PS, CLK_PS), TURN_CYC),
                   left_after(ps_to_cycles(T_SELWR_PS, CLK_PS), TURN_CYC)),
              left_after(ps_to_cycles(T_CYC_PS, CLK_PS), TURN_CYC + 1)));
  localparam int unsigned LONGEST = max2(max2(RD_CYC, TURN_CYC), DRV_CYC);
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

  ctrl_state_e state;
  logic        accept;       // request taken this cycle
  logic        capture_now;  // last read-wait cycle, byte sampled at its end

  sram_ctrl_seq #(
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC),
    .DRV_CYC (DRV_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .state      (state),
    .accept     (accept),
    .capture_now(capture_now)
  );

  sram_ctrl_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .capture_now(capture_now),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .addr_q     (mem_addr),
    .wdata_q    (mem_dq_out),
    .rdata_q    (rsp_rdata),
    .rvalid_q   (rsp_valid)
  );

  sram_ctrl_pins u_pins (
    .state       (state),
    .mem_sel_n   (mem_sel_n),
    .mem_sel     (mem_sel),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .mem_dq_drive(mem_dq_drive)
  );

  assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned RD_CYC   = 3,
  parameter int unsigned TURN_CYC = 2
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_sel_n,
  input logic mem_sel,
  input logic mem_rd_n,
  input logic mem_wr_n,
  input logic mem_dq_drive,
  input logic accept,
  input logic capture_now
);

  logic [15:0] rd_run;
  logic [15:0] wr_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      rd_run <= mem_rd_n ? 16'd0 : rd_run + 16'd1;
      wr_run <= mem_wr_n ? 16'd0 : wr_run + 16'd1;
    end
  end

  a_r1_sel_in_access: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_n || !mem_wr_n || mem_dq_drive) |-> (!mem_sel_n && mem_sel));

  a_r1_desel_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_sel_n && !mem_sel));

  a_r3_read_len: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_n) |-> (rd_run == 16'(RD_CYC)));

  a_r4_rd_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_wr_n |-> mem_rd_n);

  a_r5_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_drive) |-> (wr_run == 16'(TURN_CYC)));

  a_r5_held_at_strobe_end: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |-> mem_dq_drive);

  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_drive && mem_wr_n) |=> !mem_dq_drive);

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r6_capture_to_valid: assert property (@(posedge clk) disable iff (rst)
    capture_now |=> (rsp_valid && req_ready));

  a_r7_reset_idle: assert property (@(posedge clk)
    rst |=> (mem_sel_n && !mem_sel && mem_rd_n && mem_wr_n &&
             !mem_dq_drive && !rsp_valid && req_ready));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .RD_CYC  (RD_CYC),
  .TURN_CYC(TURN_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .mem_sel_n   (mem_sel_n),
  .mem_sel     (mem_sel),
  .mem_rd_n    (mem_rd_n),
  .mem_wr_n    (mem_wr_n),
  .mem_dq_drive(mem_dq_drive),
  .accept      (accept),
  .capture_now (capture_now)
);

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;

  // Expected phase lengths, restated from the requirements (5000 ps period).
  localparam int P = 5000;
  function automatic int up(int t);
    return (t / P) + ((t % P) != 0 ? 1 : 0);
  endfunction
  function automatic int big(int a, int b);
    return (a > b) ? a : b;
  endfunction
  localparam int RD_EXP     = big(big(up(15000), up(7000)), up(15000));
  localparam int TURN_EXP   = up(8000);
  localparam int WR_LOW_EXP = big(big(big(up(10000), up(13000)), up(13000)),
                                  big(TURN_EXP + up(9000), up(15000) - 1));
  localparam int DRV_EXP    = WR_LOW_EXP - TURN_EXP + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_rd_n, mem_wr_n, mem_dq_drive;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  always #10 clk = ~clk;  // 50 MHz

  sram_ctrl uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_drive(mem_dq_drive)
  );

  // ---- memory model: 256 slots keyed by low byte, tagged with high byte ----
  logic [7:0] m_data [256];
  logic [7:0] m_tag  [256];
  logic       m_vld  [256];

  function automatic logic [7:0] dflt(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  initial for (int i = 0; i < 256; i++) m_vld[i] = 1'b0;

  always @(posedge mem_wr_n) begin
    if (mem_sel_n === 1'b0 && mem_sel === 1'b1 && mem_dq_drive === 1'b1) begin
      m_data[mem_addr[7:0]] = mem_dq_out;
      m_tag[mem_addr[7:0]]  = mem_addr[15:8];
      m_vld[mem_addr[7:0]]  = 1'b1;
    end
  end

  always @* begin
    if (mem_sel_n === 1'b0 && mem_sel === 1'b1 && mem_rd_n === 1'b0 && mem_wr_n === 1'b1) begin
      if (m_vld[mem_addr[7:0]] && m_tag[mem_addr[7:0]] == mem_addr[15:8])
        mem_dq_in = m_data[mem_addr[7:0]];
      else
        mem_dq_in = dflt(mem_addr);
    end else begin
      mem_dq_in = 8'h00;
    end
  end

  // ---- scoreboard ----
  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q [$];
  logic [7:0] shadow [int];
  bit mon_en = 1'b0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_at(logic [15:0] a);
    if (shadow.exists(int'(a))) return shadow[int'(a)];
    return dflt(a);
  endfunction

  task automatic issue(input bit wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[int'(a)] = d;
    else    exp_q.push_back(expect_at(a));
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R6 ready low after accept", req_ready, 0);
  endtask

  // ---- monitor ----
  int rd_low = 0, wr_low = 0, drv_cnt = 0;
  logic prev_rd_n = 1'b1, prev_wr_n = 1'b1, prev_drv = 1'b0, prev_valid = 1'b0;
  int sel_viol = 0, busy_viol = 0, pulse_viol = 0, wr_rd_viol = 0;

  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (!prev_rd_n && mem_rd_n) begin
        check(rd_low == RD_EXP, "R3 read strobe length", rd_low, RD_EXP);
        check(rsp_valid == 1'b1, "R6 valid with read strobe end", rsp_valid, 1);
      end
      if (!prev_wr_n && mem_wr_n) begin
        check(wr_low == WR_LOW_EXP, "R4 write strobe length", wr_low, WR_LOW_EXP);
        check(mem_dq_drive == 1'b1, "R5 driver held past strobe end", mem_dq_drive, 1);
      end
      if (!prev_drv && mem_dq_drive)
        check(wr_low == TURN_EXP, "R5 turnaround before drive", wr_low, TURN_EXP);
      if (prev_drv && !mem_dq_drive)
        check(drv_cnt == DRV_EXP, "R5 driver on length", drv_cnt, DRV_EXP);
      if (rsp_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R2 response with nothing pending", rsp_rdata, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          check(rsp_rdata == e, "R2 read data", rsp_rdata, e);
        end
      end
      if (rsp_valid && prev_valid) pulse_viol++;
      if (req_ready && (!mem_sel_n || mem_sel)) busy_viol++;
      if (mem_sel_n == mem_sel) sel_viol++;
      if (!mem_wr_n && !mem_rd_n) wr_rd_viol++;
    end
    rd_low  = mem_rd_n ? 0 : rd_low + 1;
    wr_low  = mem_wr_n ? 0 : wr_low + 1;
    drv_cnt = mem_dq_drive ? drv_cnt + 1 : 0;
    prev_rd_n = mem_rd_n; prev_wr_n = mem_wr_n;
    prev_drv = mem_dq_drive; prev_valid = rsp_valid;
  end

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic idle_pins(input string tag);
    check(mem_sel_n && !mem_sel, {tag, " select pair idle"}, {mem_sel_n, mem_sel}, 2'b10);
    check(mem_rd_n && mem_wr_n && !mem_dq_drive, {tag, " strobes idle"},
          {mem_rd_n, mem_wr_n, mem_dq_drive}, 3'b110);
    check(req_ready && !rsp_valid, {tag, " ready idle"}, {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_pins("R7 reset");
    rst = 1'b0;
    mon_en = 1'b1;

    issue(1'b1, 16'h1234, 8'hC3);
    issue(1'b0, 16'h1234, 8'h00);          // R2 readback
    issue(1'b0, 16'h0034, 8'h00);          // R2 upper bits matter
    issue(1'b1, 16'h0000, 8'h11);
    issue(1'b1, 16'hFFFF, 8'hEE);
    issue(1'b0, 16'hFFFF, 8'h00);          // R2 top address
    issue(1'b0, 16'h0000, 8'h00);          // R2 bottom address
    issue(1'b0, 16'h8001, 8'h00);          // read then write back to back: R5
    issue(1'b1, 16'h8001, 8'h7E);
    issue(1'b0, 16'h8001, 8'h00);
    issue(1'b1, 16'h1234, 8'h00);
    issue(1'b0, 16'h1234, 8'h00);

    // R7: reset inside a write's turnaround phase
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    mon_en = 1'b0;
    issue(1'b1, 16'h4242, 8'h99);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    idle_pins("R7 abort");
    rst = 1'b0;
    shadow.delete(int'(16'h4242));
    @(negedge clk);
    mon_en = 1'b1;
    issue(1'b0, 16'h4242, 8'h00);          // R7 aborted write left memory alone
    issue(1'b1, 16'h5A5A, 8'h3C);
    issue(1'b0, 16'h5A5A, 8'h00);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sel_viol == 0, "R1 select pins never equal", sel_viol, 0);
    check(busy_viol == 0, "R1 deselected whenever ready", busy_viol, 0);
    check(wr_rd_viol == 0, "R4 read enable high in write", wr_rd_viol, 0);
    check(pulse_viol == 0, "R6 valid lasts one cycle", pulse_viol, 0);
    summary();
  end

endmodule